// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two entries from a page table held in memory. A translation request carries the virtual address. The block also samples a table base input at the same moment. It splits the address into a 10-bit first-level index, a 10-bit second-level index and a 12-bit page offset. It fetches the first-level entry, which names the frame that holds the second-level table. It then fetches the second-level entry, which names the frame of the data page.

Each entry is one 32-bit word. Bit 0 is the valid flag and bits 31:12 are a frame number. Bits 11:1 are reserved and have no effect. If either entry is invalid, the block reports a page fault and says which level caused it, in place of a translation. Table reads go out on a plain valid/ready read request channel. The 32-bit response comes back in a single beat, after any delay.

The walker serves one request at a time. Its request-ready output is high only while it is idle. The result appears as a one-cycle response pulse.

Top module: `ptw_walker`

## Requirements
- R1: Out of reset the walker is idle: `busy` low, `req_ready` high, and `mem_req_valid` and `rsp_valid` both low.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. The virtual address and the table base are captured at that edge. Changes to `req_valid`, `req_vaddr` or `ptbr` while the walker is busy have no effect on the walk in progress.
- R3: The first table read goes to `ptbr + 4*vaddr[31:22]`, taken modulo 2^32.
- R4: The second table read goes to `{L1entry[31:12], vaddr[21:12], 2'b00}`.
- R5: If bit 0 of the first-level entry is 0, the walker issues no second read. It responds with `rsp_fault`=1 and `rsp_fault_lvl`=0, where 0 means the first level.
- R6: If bit 0 of the second-level entry is 0, the walker responds with `rsp_fault`=1 and `rsp_fault_lvl`=1, where 1 means the second level.
- R7: If both entries are valid, the walker responds with `rsp_fault`=0 and `rsp_paddr = {L2entry[31:12], vaddr[11:0]}`. Entry bits 11:1 have no effect.
- R8: A table read request keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready` is seen. The walker then waits any number of cycles for `mem_rsp_valid`. It ignores `mem_rsp_valid` in any cycle where it is not waiting for a response.
- R9: `busy` is high from the cycle after acceptance through the cycle of the response. `rsp_valid` is high for exactly one cycle, and the walker is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| ptbr | input | 32 | Physical base address of the first-level table |
| busy | output | 1 | Walk in progress |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Page fault instead of translation |
| rsp_fault_lvl | output | 1 | Level that faulted (0 first, 1 second) |
| rsp_paddr | output | 32 | Translated physical address (zero when not a valid result) |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word returned |

## Verification
Some properties are checked on every cycle. No table read is issued while the walker is idle or while it waits for a response. A stalled read keeps its address. The first read address follows from the captured base and index, and the low bits of the second read address follow from the captured second index. The page offset passes straight through. The number of reads before each kind of outcome is right, and the response is a single pulse followed by idle.

Other behaviour needs the bench's sweep. That sweep runs over many index and offset patterns and several table bases, against a computed memory image. It covers the frame numbers, which depend on the memory contents. It covers faults at each level, with the reserved entry bits set to arbitrary values. It also covers the effect of random ready stalls, variable response delays, stray response pulses and request inputs that change during a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        WS_IDLE    = 3'd0,
        WS_READ_L1 = 3'd1,
        WS_READ_L2 = 3'd2,
        WS_DONE    = 3'd3,
        WS_FAULT   = 3'd4
    } walk_state_e;

    // fault level encoding on rsp_fault_lvl
    localparam logic LVL_FIRST  = 1'b0;
    localparam logic LVL_SECOND = 1'b1;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
    parameter int VA_W  = 32,
    parameter int L1_W  = 10,
    parameter int L2_W  = 10,
    parameter int OFF_W = 12
) (
    input  logic [VA_W-1:0]  va,
    output logic [L1_W-1:0]  idx_l1,
    output logic [L2_W-1:0]  idx_l2,
    output logic [OFF_W-1:0] offset
);
    // top field indexes the first table, middle field the second
    assign idx_l1 = va[VA_W-1 -: L1_W];
    assign idx_l2 = va[OFF_W +: L2_W];
    assign offset = va[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int PA_W        = 32,
    parameter int IDX_W       = 10,
    parameter int FRAME_W     = 20,
    parameter int ENTRY_SHIFT = 2,
    parameter bit FROM_FRAME  = 1'b0
) (
    input  logic [PA_W-1:0]    base,
    input  logic [FRAME_W-1:0] frame,
    input  logic [IDX_W-1:0]   idx,
    output logic [PA_W-1:0]    addr
);
    generate
        if (FROM_FRAME) begin : g_frame
            // table is page aligned: concatenate frame, index, byte-in-entry zeros
            logic unused_base;
            assign unused_base = ^base;
            assign addr = {frame, idx, {ENTRY_SHIFT{1'b0}}};
        end else begin : g_base
            // arbitrary base: full add of the scaled index
            logic unused_frame;
            assign unused_frame = ^frame;
            assign addr = base + (PA_W'(idx) << ENTRY_SHIFT);
        end
    endgenerate
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int PTE_W   = 32,
    parameter int FRAME_W = 20
) (
    input  logic [PTE_W-1:0]   pte,
    output logic               valid,
    output logic [FRAME_W-1:0] frame
);
    localparam int RSVD_HI = PTE_W - FRAME_W - 1;

    logic unused_rsvd;
    assign unused_rsvd = ^pte[RSVD_HI:1];

    assign valid = pte[0];
    assign frame = pte[PTE_W-1 -: FRAME_W];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int L1_W        = 10,
    parameter int L2_W        = 10,
    parameter int ENTRY_SHIFT = 2,
    parameter int PTE_W       = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [PA_W-1:0] ptbr,
    output logic            busy,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic            rsp_fault_lvl,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);
    localparam int OFF_W   = VA_W - L1_W - L2_W;
    localparam int FRAME_W = PA_W - OFF_W;

    typedef struct packed {
        walk_state_e        state;
        logic               issued;
        logic [VA_W-1:0]    va;
        logic [PA_W-1:0]    base;
        logic [FRAME_W-1:0] frame;
        logic               lvl;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [L1_W-1:0]    idx_l1;
    logic [L2_W-1:0]    idx_l2;
    logic [OFF_W-1:0]   offset;
    logic [PA_W-1:0]    addr_l1;
    logic [PA_W-1:0]    addr_l2;
    logic               pte_valid;
    logic [FRAME_W-1:0] pte_frame;
    logic               in_read;

    ptw_va_split #(
        .VA_W (VA_W), .L1_W (L1_W), .L2_W (L2_W), .OFF_W (OFF_W)
    ) u_split (
        .va     (r_q.va),
        .idx_l1 (idx_l1),
        .idx_l2 (idx_l2),
        .offset (offset)
    );

    ptw_entry_addr #(
        .PA_W (PA_W), .IDX_W (L1_W), .FRAME_W (FRAME_W),
        .ENTRY_SHIFT (ENTRY_SHIFT), .FROM_FRAME (1'b0)
    ) u_addr_l1 (
        .base  (r_q.base),
        .frame (r_q.frame),
        .idx   (idx_l1),
        .addr  (addr_l1)
    );

    ptw_entry_addr #(
        .PA_W (PA_W), .IDX_W (L2_W), .FRAME_W (FRAME_W),
        .ENTRY_SHIFT (ENTRY_SHIFT), .FROM_FRAME (1'b1)
    ) u_addr_l2 (
        .base  (r_q.base),
        .frame (r_q.frame),
        .idx   (idx_l2),
        .addr  (addr_l2)
    );

    ptw_pte_decode #(
        .PTE_W (PTE_W), .FRAME_W (FRAME_W)
    ) u_decode (
        .pte   (mem_rsp_data),
        .valid (pte_valid),
        .frame (pte_frame)
    );

    assign in_read = (r_q.state == WS_READ_L1) || (r_q.state == WS_READ_L2);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            WS_IDLE: begin
                if (req_valid) begin
                    r_d.state  = WS_READ_L1;
                    r_d.issued = 1'b0;
                    r_d.va     = req_vaddr;
                    r_d.base   = ptbr;
                end
            end
            WS_READ_L1, WS_READ_L2: begin
                if (!r_q.issued) begin
                    if (mem_req_ready) begin
                        r_d.issued = 1'b1;
                    end
                end else if (mem_rsp_valid) begin
                    r_d.issued = 1'b0;
                    if (!pte_valid) begin
                        r_d.state = WS_FAULT;
                        r_d.lvl   = (r_q.state == WS_READ_L2) ? LVL_SECOND : LVL_FIRST;
                    end else begin
                        r_d.frame = pte_frame;
                        r_d.state = (r_q.state == WS_READ_L1) ? WS_READ_L2 : WS_DONE;
                    end
                end
            end
            WS_DONE, WS_FAULT: begin
                r_d.state = WS_IDLE;
            end
            default: begin
                r_d.state = WS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= WS_IDLE;
            r_q.issued <= 1'b0;
            r_q.va     <= '0;
            r_q.base   <= '0;
            r_q.frame  <= '0;
            r_q.lvl    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.state == WS_IDLE);
    assign busy          = (r_q.state != WS_IDLE);
    assign mem_req_valid = in_read && !r_q.issued;
    assign mem_req_addr  = (r_q.state == WS_READ_L2) ? addr_l2 : addr_l1;
    assign rsp_valid     = (r_q.state == WS_DONE) || (r_q.state == WS_FAULT);
    assign rsp_fault     = (r_q.state == WS_FAULT);
    assign rsp_fault_lvl = (r_q.state == WS_FAULT) ? r_q.lvl : 1'b0;
    assign rsp_paddr     = (r_q.state == WS_DONE) ? {r_q.frame, offset} : '0;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int L1_W        = 10,
    parameter int L2_W        = 10,
    parameter int ENTRY_SHIFT = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic [PA_W-1:0] ptbr,
    input logic            busy,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic            rsp_fault_lvl,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid
);
    localparam int OFF_W = VA_W - L1_W - L2_W;

    logic [VA_W-1:0] va_cap;
    logic [PA_W-1:0] base_cap;
    logic [1:0]      hs_cnt;
    logic            waiting;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_cap   <= '0;
            base_cap <= '0;
            hs_cnt   <= '0;
            waiting  <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                va_cap   <= req_vaddr;
                base_cap <= ptbr;
                hs_cnt   <= '0;
            end else if (mem_req_valid && mem_req_ready) begin
                hs_cnt <= hs_cnt + 2'd1;
            end
            if (mem_req_valid && mem_req_ready) begin
                waiting <= 1'b1;
            end else if (mem_rsp_valid) begin
                waiting <= 1'b0;
            end
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !rsp_valid));

    assert_l1_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && hs_cnt == 2'd0) |->
        mem_req_addr == base_cap + (PA_W'(va_cap[VA_W-1 -: L1_W]) << ENTRY_SHIFT));

    assert_l2_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && hs_cnt == 2'd1) |->
        mem_req_addr[OFF_W-1:0] == {va_cap[OFF_W +: L2_W], {ENTRY_SHIFT{1'b0}}});

    assert_l1_fault_one_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && !rsp_fault_lvl) |-> hs_cnt == 2'd1);

    assert_l2_outcome_two_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (!rsp_fault || rsp_fault_lvl)) |-> hs_cnt == 2'd2);

    assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_paddr[OFF_W-1:0] == va_cap[OFF_W-1:0]);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_no_req_while_waiting_R8: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> !mem_req_valid);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

endmodule

bind ptw_walker ptw_walker_chk #(
    .VA_W (VA_W), .PA_W (PA_W), .L1_W (L1_W), .L2_W (L2_W), .ENTRY_SHIFT (ENTRY_SHIFT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .ptbr          (ptbr),
    .busy          (busy),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .rsp_paddr     (rsp_paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] ptbr = '0;
    logic        busy, rsp_valid, rsp_fault, rsp_fault_lvl;
    logic [31:0] rsp_paddr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int n_ok = 0, n_f1 = 0, n_f2 = 0;

    // memory model state
    bit          pending = 0;
    int          dly = 0;
    logic [31:0] pend_addr = '0;
    logic [31:0] hs_addr [2];
    int          hs_n = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit          stall_prev = 0;
    logic [31:0] stall_addr = '0;

    always #5 clk = ~clk;

    ptw_walker dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_vaddr (req_vaddr), .ptbr (ptbr),
        .busy (busy), .rsp_valid (rsp_valid), .rsp_fault (rsp_fault),
        .rsp_fault_lvl (rsp_fault_lvl), .rsp_paddr (rsp_paddr),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

    // computed memory image: frame and reserved bits arbitrary, ~25% invalid
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] h;
        h = (a * 32'h9E3779B1) ^ (a >> 7);
        return {h[31:12], h[11:1] ^ a[12:2], (h[20:18] >= 3'd2)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // memory responder, acts on falling edges
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = {lfsr, ~lfsr};
            if (pending) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(pend_addr);
                    pending = 0;
                end else begin
                    dly--;
                end
            end else if (lfsr[5:3] == 3'd0) begin
                mem_rsp_valid = 1'b1;      // stray pulse, must be ignored (R8)
                mem_rsp_data  = 32'hFFFF_F001;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (stall_prev && rst_n) begin
                check(mem_req_valid && mem_req_addr == stall_addr,
                      "R8 stalled request held", mem_req_addr, stall_addr);
            end
            mem_req_ready = lfsr[0] | lfsr[1];
            stall_prev = mem_req_valid && !mem_req_ready;
            stall_addr = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                pending   = 1;
                dly       = int'(lfsr[3:2]);
                pend_addr = mem_req_addr;
                if (hs_n < 2) hs_addr[hs_n] = mem_req_addr;
                hs_n++;
            end
        end
    end

    task automatic do_walk(input logic [31:0] va, input logic [31:0] base);
        logic [31:0] a1, e1, a2, e2, exp_pa;
        int exp_reads, wait_n;
        bit exp_fault, exp_lvl;
        a1 = base + {20'd0, va[31:22], 2'b00};
        e1 = mem_word(a1);
        a2 = {e1[31:12], va[21:12], 2'b00};
        e2 = mem_word(a2);
        exp_pa = {e2[31:12], va[11:0]};
        if (!e1[0]) begin
            exp_fault = 1; exp_lvl = 0; exp_reads = 1;
        end else if (!e2[0]) begin
            exp_fault = 1; exp_lvl = 1; exp_reads = 2;
        end else begin
            exp_fault = 0; exp_lvl = 0; exp_reads = 2;
        end

        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready when idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = va; ptbr = base;
        hs_n = 0;
        @(negedge clk);
        check(busy && !req_ready, "R9 busy after accept", {30'd0, busy, req_ready}, 32'd2);
        // inputs churn while busy: must not affect the walk (R2)
        req_vaddr = ~va; ptbr = base ^ 32'h0BAD_F00C;
        wait_n = 0;
        while (!rsp_valid && wait_n < 200) begin
            @(negedge clk);
            check(busy || rsp_valid, "R9 busy through walk", {31'd0, busy}, 32'd1);
            wait_n++;
        end
        req_valid = 1'b0;
        check(rsp_valid, "R9 response arrives", {31'd0, rsp_valid}, 32'd1);
        check(rsp_fault == exp_fault, "R2 fault flag", {31'd0, rsp_fault}, {31'd0, exp_fault});
        check(hs_n == exp_reads, "R5 number of table reads", hs_n, exp_reads);
        check(hs_addr[0] == a1, "R3 first-level address", hs_addr[0], a1);
        if (exp_reads == 2)
            check(hs_addr[1] == a2, "R4 second-level address", hs_addr[1], a2);
        if (exp_fault && !exp_lvl) begin
            n_f1++;
            check(rsp_fault_lvl == 1'b0, "R5 first-level fault", {31'd0, rsp_fault_lvl}, 32'd0);
        end else if (exp_fault) begin
            n_f2++;
            check(rsp_fault_lvl == 1'b1, "R6 second-level fault", {31'd0, rsp_fault_lvl}, 32'd1);
        end else begin
            n_ok++;
            check(rsp_paddr == exp_pa, "R7 physical address", rsp_paddr, exp_pa);
        end
        @(negedge clk);
        check(!rsp_valid && !busy && req_ready, "R9 single pulse then idle",
              {29'd0, rsp_valid, busy, req_ready}, 32'd1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] bases [3];
        bases[0] = 32'h0001_0000;
        bases[1] = 32'hFFFF_F800;   // wraps past 2^32 for high indices
        bases[2] = 32'h0000_0004;
        repeat (3) @(negedge clk);
        check(!busy && req_ready && !mem_req_valid && !rsp_valid, "R1 reset state",
              {28'd0, busy, req_ready, mem_req_valid, rsp_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && req_ready && !mem_req_valid && !rsp_valid, "R1 idle after reset",
              {28'd0, busy, req_ready, mem_req_valid, rsp_valid}, 32'h4);

        // corner indices and offsets
        for (int b = 0; b < 3; b++) begin
            for (int c = 0; c < 8; c++) begin
                logic [9:0]  i1, i2;
                logic [11:0] off;
                i1  = c[0] ? 10'h3FF : 10'h000;
                i2  = c[1] ? 10'h3FF : 10'h000;
                off = c[2] ? 12'hFFF : 12'h000;
                do_walk({i1, i2, off}, bases[b]);
            end
        end
        // arithmetic sweep
        for (int b = 0; b < 3; b++) begin
            for (int k = 0; k < 120; k++) begin
                logic [9:0]  i1, i2;
                logic [11:0] off;
                i1  = 10'((k * 97 + b * 13) % 1024);
                i2  = 10'((k * 181 + 7) % 1024);
                off = 12'((k * 293 + b) % 4096);
                do_walk({i1, i2, off}, bases[b]);
            end
        end
        check(n_f1 > 0, "R5 first-level faults seen", n_f1, 32'd1);
        check(n_f2 > 0, "R6 second-level faults seen", n_f2, 32'd1);
        check(n_ok > 0, "R7 translations seen", n_ok, 32'd1);
        finish_run();
    end
endmodule